// File: doc/BRIEF.md
# Receive FIFO Pause Frame Trigger

This block watches how full a receive FIFO is and tells a MAC when to send flow-control pause frames. Two programmable thresholds, each counted in 64-byte quanta, give hysteresis. When the FIFO fills past the upper (stop) threshold, the block asks the MAC to send a pause frame that carries the programmed pause time. It then waits for the MAC to acknowledge that request.

After the stop request is acknowledged, the block waits for the FIFO to drain below the lower (resume) threshold. It then asks for a second pause frame with a pause time of zero and waits for that acknowledge too. Only then does it go back to watching for the stop condition. The pause frame itself is framed and sent elsewhere. This block only raises the request, holds the pause-time value that goes with it, and shows its state as a two-bit code.

Top module: `rx_pause_ctl`

## Requirements
- R1: While reset is asserted and right after it, the state code is 0 (idle), the send request is low and the pause value is 0.
- R2: In idle, when the stop threshold is non-zero and the FIFO level is strictly greater than stop threshold × 64, the state code becomes 1 and the send request rises one clock later.
- R3: A stop request carries the pause time that was present on the cycle its condition was seen. The pause value holds that number until the request is acknowledged, even if the pause-time input changes.
- R4: The send request stays high until the acknowledge input is seen in the same cycle. An acknowledge in state 1 moves the state code to 2 and drops the request one clock later.
- R5: In state 2, when the level is strictly below resume threshold × 64, the state code becomes 3 one clock later, with the request high and the pause value 0.
- R6: An acknowledge in state 3 returns the state code to 0 one clock later. The thresholds are compared again only from that point on.
- R7: A stop threshold of 0 disables flow control: the state code stays 0 whatever the level is.
- R8: If resume threshold × 64 is equal to or above the FIFO capacity (parameter, 16384 bytes by default), the block never leaves state 2.
- R9: The state code uses these values: 0 = idle, 1 = waiting for the stop acknowledge, 2 = waiting for the resume condition, 3 = waiting for the resume acknowledge. From each state, the only moves are 0→1, 1→2, 2→3 and 3→0.
- R10: A level exactly equal to stop threshold × 64 does not start a stop request. A level exactly equal to resume threshold × 64 does not start a resume request.
- R11: An acknowledge has no effect in states 0 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fifoLevel | input | 15 | Receive FIFO occupancy in bytes |
| offThresh | input | 9 | Stop threshold in 64-byte quanta (0 disables) |
| onThresh | input | 9 | Resume threshold in 64-byte quanta |
| pauseTime | input | 16 | Pause time to place in a stop request |
| macAck | input | 1 | MAC acknowledges the pending request |
| pauseReq | output | 1 | Request to send a pause frame |
| pauseValue | output | 16 | Pause time for the pending request |
| stateCode | output | 2 | Current controller state |

## Verification
Every result is registered once. A level or acknowledge that is sampled at one rising edge shows up in the state code, the request and the pause value right after that same edge, so it can be seen on the following falling edge. The bench changes its inputs only on falling edges. It advances its behavioural model on the rising edge that consumes those inputs, and it compares all three outputs with the model on the next falling edge, before any new input is applied. Boundary and ignored-input cases are checked at those same falling edges, a full cycle after the stimulus.

// File: rtl/rx_pause_ctl_pkg.sv
package rx_pause_ctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_XOFF_ACK = 2'd1,
    ST_WAIT_XON = 2'd2,
    ST_XON_ACK  = 2'd3
  } pauseState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadXoff;
    logic loadXon;
  } dpCtl_t;

endpackage

// File: rtl/rx_pause_ctl_dp.sv
module rx_pause_ctl_dp
  import rx_pause_ctl_pkg::*;
#(
  parameter int LEVEL_W     = 15,
  parameter int THR_W       = 9,
  parameter int QUANT_SHIFT = 6,
  parameter int TIME_W      = 16,
  parameter int FIFO_BYTES  = 16384
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LEVEL_W-1:0] fifoLevel,
  input  logic [THR_W-1:0]   offThresh,
  input  logic [THR_W-1:0]   onThresh,
  input  logic [TIME_W-1:0]  pauseTime,
  input  dpCtl_t             ctl,
  output logic               overOff,
  output logic               underOn,
  output logic [TIME_W-1:0]  pauseValue
);

  localparam int BYTE_W = THR_W + QUANT_SHIFT;
  localparam int CMP_W  = (LEVEL_W > BYTE_W) ? LEVEL_W : BYTE_W;

  logic [CMP_W-1:0] levelExt;
  logic [CMP_W-1:0] offBytes;
  logic [CMP_W-1:0] onBytes;
  logic             onUsable;

  assign levelExt = CMP_W'(fifoLevel);
  assign offBytes = CMP_W'({offThresh, {QUANT_SHIFT{1'b0}}});
  assign onBytes  = CMP_W'({onThresh, {QUANT_SHIFT{1'b0}}});
  assign onUsable = (32'(onBytes) < FIFO_BYTES);

  assign overOff = (offThresh != '0) && (levelExt > offBytes);
  assign underOn = onUsable && (levelExt < onBytes);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pauseValue <= '0;
    end else if (ctl.loadXoff) begin
      pauseValue <= pauseTime;
    end else if (ctl.loadXon) begin
      pauseValue <= '0;
    end
  end

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.loadXoff && ctl.loadXon));

  // R5
  xon_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadXon |=> (pauseValue == '0));

endmodule

// File: rtl/rx_pause_ctl_fsm.sv
module rx_pause_ctl_fsm
  import rx_pause_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        overOff,
  input  logic        underOn,
  input  logic        macAck,
  output dpCtl_t      ctl,
  output pauseState_e state,
  output logic        pauseReq
);

  pauseState_e stateNext;

  always_comb begin
    stateNext = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: if (overOff) begin
        stateNext    = ST_XOFF_ACK;
        ctl.loadXoff = 1'b1;
      end
      ST_XOFF_ACK: if (macAck) stateNext = ST_WAIT_XON;
      ST_WAIT_XON: if (underOn) begin
        stateNext   = ST_XON_ACK;
        ctl.loadXon = 1'b1;
      end
      ST_XON_ACK: if (macAck) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign pauseReq = (state == ST_XOFF_ACK) || (state == ST_XON_ACK);

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pauseReq && !macAck) |=> pauseReq);

  // R9
  wait_xon_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_XON) |=> (state == ST_WAIT_XON || state == ST_XON_ACK));

  // R11
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !overOff) |=> (state == ST_IDLE));

endmodule

// File: rtl/rx_pause_ctl.sv
module rx_pause_ctl
  import rx_pause_ctl_pkg::*;
#(
  parameter int LEVEL_W     = 15,
  parameter int THR_W       = 9,
  parameter int QUANT_SHIFT = 6,
  parameter int TIME_W      = 16,
  parameter int FIFO_BYTES  = 16384
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LEVEL_W-1:0] fifoLevel,
  input  logic [THR_W-1:0]   offThresh,
  input  logic [THR_W-1:0]   onThresh,
  input  logic [TIME_W-1:0]  pauseTime,
  input  logic               macAck,
  output logic               pauseReq,
  output logic [TIME_W-1:0]  pauseValue,
  output logic [1:0]         stateCode
);

  dpCtl_t      ctl;
  pauseState_e state;
  logic        overOff;
  logic        underOn;

  rx_pause_ctl_dp #(
    .LEVEL_W(LEVEL_W), .THR_W(THR_W), .QUANT_SHIFT(QUANT_SHIFT),
    .TIME_W(TIME_W), .FIFO_BYTES(FIFO_BYTES)
  ) dp (
    .clk(clk), .rstN(rstN), .fifoLevel(fifoLevel), .offThresh(offThresh),
    .onThresh(onThresh), .pauseTime(pauseTime), .ctl(ctl),
    .overOff(overOff), .underOn(underOn), .pauseValue(pauseValue)
  );

  rx_pause_ctl_fsm fsm (
    .clk(clk), .rstN(rstN), .overOff(overOff), .underOn(underOn),
    .macAck(macAck), .ctl(ctl), .state(state), .pauseReq(pauseReq)
  );

  assign stateCode = state;

  // R3
  value_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pauseReq && !macAck) |=> $stable(pauseValue));

  // R7
  off_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 2'd0 && offThresh == '0) |=> (stateCode == 2'd0));

  // R5
  xon_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 2'd3) |-> (pauseValue == '0));

endmodule

// File: tb/rx_pause_ctl_test.sv
`timescale 1ns/1ps
module rx_pause_ctl_test;

  localparam int FIFO_BYTES = 16384;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [14:0] fifoLevel = '0;
  logic [8:0]  offThresh = '0;
  logic [8:0]  onThresh = '0;
  logic [15:0] pauseTime = '0;
  logic        macAck = 1'b0;
  logic        pauseReq;
  logic [15:0] pauseValue;
  logic [1:0]  stateCode;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string curReq = "R1";

  int refState = 0;
  int refValue = 0;

  always #4 clk = ~clk;

  rx_pause_ctl uut (
    .clk(clk), .rstN(rstN), .fifoLevel(fifoLevel), .offThresh(offThresh),
    .onThresh(onThresh), .pauseTime(pauseTime), .macAck(macAck),
    .pauseReq(pauseReq), .pauseValue(pauseValue), .stateCode(stateCode)
  );

  // behavioural reference
  always @(posedge clk) begin
    if (!rstN) begin
      refState = 0;
      refValue = 0;
    end else begin
      case (refState)
        0: if (offThresh != 0 && int'(fifoLevel) > int'(offThresh) * 64) begin
             refState = 1;
             refValue = int'(pauseTime);
           end
        1: if (macAck) refState = 2;
        2: if (int'(onThresh) * 64 < FIFO_BYTES && int'(fifoLevel) < int'(onThresh) * 64) begin
             refState = 3;
             refValue = 0;
           end
        default: if (macAck) refState = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (int'(stateCode) != refState || pauseReq != (refState == 1 || refState == 3)
          || int'(pauseValue) != refValue) begin
        errors++;
        $display("FAIL %s model: state=%0d req=%0b val=%h expected state=%0d req=%0b val=%h",
                 curReq, stateCode, pauseReq, pauseValue, refState,
                 (refState == 1 || refState == 3), refValue);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expectOut(input string tag, input int st, input bit req, input int val);
    checks++;
    if (int'(stateCode) != st || pauseReq != req || int'(pauseValue) != val) begin
      errors++;
      $display("FAIL %s: state=%0d req=%0b val=%h expected state=%0d req=%0b val=%h",
               tag, stateCode, pauseReq, pauseValue, st, req, val);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(2);
    expectOut("R1 in reset", 0, 0, 0);
    rstN = 1'b1;
    step(1);
    expectOut("R1 after reset", 0, 0, 0);

    curReq = "R10";
    offThresh = 9'd2; onThresh = 9'd1; pauseTime = 16'h1234;
    fifoLevel = 15'd128;
    step(3);
    expectOut("R10 level equal stop", 0, 0, 0);

    curReq = "R2";
    fifoLevel = 15'd129;
    step(1);
    expectOut("R2 stop request", 1, 1, 16'h1234);

    curReq = "R3";
    pauseTime = 16'h5555;
    step(4);
    expectOut("R3 value held", 1, 1, 16'h1234);
    curReq = "R4";
    expectOut("R4 held without ack", 1, 1, 16'h1234);
    macAck = 1'b1;
    step(1);
    expectOut("R4 ack drops req", 2, 0, 16'h1234);

    curReq = "R11";
    step(3);
    macAck = 1'b0;
    expectOut("R11 ack in state 2", 2, 0, 16'h1234);

    curReq = "R10";
    fifoLevel = 15'd64;
    step(2);
    expectOut("R10 level equal resume", 2, 0, 16'h1234);

    curReq = "R5";
    fifoLevel = 15'd63;
    step(1);
    expectOut("R5 resume request", 3, 1, 0);
    step(2);
    expectOut("R5 held", 3, 1, 0);

    curReq = "R6";
    macAck = 1'b1;
    step(1);
    macAck = 1'b0;
    expectOut("R6 back to idle", 0, 0, 0);

    curReq = "R11";
    macAck = 1'b1;
    step(2);
    macAck = 1'b0;
    expectOut("R11 ack in idle", 0, 0, 0);

    curReq = "R7";
    offThresh = 9'd0;
    fifoLevel = 15'd16000;
    step(5);
    expectOut("R7 disabled", 0, 0, 0);

    curReq = "R8";
    offThresh = 9'd10; onThresh = 9'd300; pauseTime = 16'hBEEF;
    fifoLevel = 15'd700;
    step(1);
    expectOut("R8 stop", 1, 1, 16'hBEEF);
    macAck = 1'b1;
    step(1);
    macAck = 1'b0;
    fifoLevel = 15'd0;
    step(10);
    expectOut("R8 no resume", 2, 0, 16'hBEEF);
    onThresh = 9'd256;
    step(3);
    expectOut("R8 at capacity", 2, 0, 16'hBEEF);
    onThresh = 9'd5;
    step(1);
    expectOut("R9 code 3", 3, 1, 0);
    macAck = 1'b1;
    step(1);
    macAck = 1'b0;
    expectOut("R9 code 0", 0, 0, 0);

    curReq = "R9";
    offThresh = 9'd50; onThresh = 9'd20;
    for (int i = 0; i < 3000; i++) begin
      fifoLevel = 15'($urandom_range(0, 4200));
      macAck = 1'($urandom_range(0, 3) == 0);
      pauseTime = 16'($urandom);
      step(1);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule